// File: doc/BRIEF.md
# Interrupt Controller Command-Word Sequencer

This block sits at the register edge of an eight-input programmable interrupt controller. Software reaches it through two byte-wide ports, chosen by one address bit (`port_sel`). Writes to these ports carry initialization words and operational commands, and reads return controller registers. The block works out where each write goes from three things: the port, a few data bits (bits 3, 4 and 7 on the even port), and how far the initialization sequence has got. It then keeps the configuration fields and command strobes that the priority core consumes.

Initialization always begins with a start word on the even port, and the start word itself chooses how many words follow. The base vector word always comes next. A cascade word follows only in a multi-controller setup. A mode word follows only when the start word asks for it. Once the last expected word has been taken, the block reports itself initialized. From then on, odd-port writes load the interrupt mask, and even-port writes are either priority/end-of-interrupt commands, which are passed on as a one-cycle strobe, or read-select commands. A read-select command decides whether even-port reads return the in-service register or the request register. The poll bit and the special-mask bit that a read-select command carries are kept as state only and change nothing else in the block.

Top module: `irqc_cmdword_seq`

## Requirements
- R1: While `rst` is high, and after it falls until the first write, `init_done`, `irq_mask`, `cmd_strobe`, `rd_sel_isr`, `poll_req`, `smask_mode` and `rd_data` are all 0.
- R2: An even-port write with bit 4 set starts initialization, also in the middle of an earlier sequence. In the next cycle `init_done` is 0, `irq_mask` is 0, `rd_sel_isr` is 0, `cascade_cfg` is 0, `auto_eoi` is 0 and `nested_special` is 0. The same write latches bit 3 into `level_trig`, bit 1 into `single_mode` and bit 0 into `need_w4`.
- R3: The first odd-port write after a start word is the base vector word, and its whole byte appears on `base_type`.
- R4: A cascade word is expected only when `single_mode` is 0. In that case the next odd-port write after the base word loads `cascade_cfg`. When `single_mode` is 1, that write is not a cascade word, and `cascade_cfg` stays 0.
- R5: A mode word is expected only when `need_w4` is 1. It is the next odd-port write after the last earlier word, and it loads `auto_eoi` from bit 1 and `nested_special` from bit 4.
- R6: `init_done` rises in the cycle after the last expected word is written, and not before. The shortest sequence is a start word plus a base word.
- R7: While `init_done` is 0, odd-port writes other than initialization words, and even-port writes with bit 4 clear, have no effect: `irq_mask` does not change and `cmd_strobe` stays 0.
- R8: While `init_done` is 1, an odd-port write loads `irq_mask`. An odd-port read returns `irq_mask` on `rd_data` in the next cycle.
- R9: While `init_done` is 1, an even-port write with bits 4 and 3 both clear makes `cmd_strobe` high for the next cycle, with the written byte on `cmd_code`.
- R10: While `init_done` is 1, an even-port write with bit 3 set and bits 4 and 7 clear is a read-select command, and it acts as follows:
  - When bit 1 is set, `rd_sel_isr` takes bit 0 (1 selects in-service, 0 selects request). When bit 1 is clear, `rd_sel_isr` keeps its value.
  - `poll_req` takes bit 2.
  - `smask_mode` takes bit 5, but only when bit 6 is set.
  - An even-port write with bits 3 and 7 set and bit 4 clear changes nothing.
- R11: An even-port read returns `isr_in` when `rd_sel_isr` is 1, and `irr_in` otherwise, on `rd_data` one cycle later. `rd_data` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| port_sel | input | 1 | Port address bit: 0 = even port, 1 = odd port |
| wr_data | input | 8 | Write byte |
| isr_in | input | 8 | In-service register from the priority core |
| irr_in | input | 8 | Request register from the priority core |
| rd_data | output | 8 | Registered read byte |
| init_done | output | 1 | Initialization complete |
| level_trig | output | 1 | Level-triggered inputs selected |
| single_mode | output | 1 | Single-controller setup (no cascade word) |
| need_w4 | output | 1 | Mode word expected |
| base_type | output | 8 | Base vector byte |
| cascade_cfg | output | 8 | Cascade configuration byte |
| auto_eoi | output | 1 | Automatic end-of-interrupt selected |
| nested_special | output | 1 | Special fully nested mode selected |
| irq_mask | output | 8 | Interrupt mask |
| cmd_strobe | output | 1 | One-cycle priority/EOI command strobe |
| cmd_code | output | 8 | Priority/EOI command byte |
| rd_sel_isr | output | 1 | Even-port read source: 1 = in-service, 0 = request |
| poll_req | output | 1 | Stored poll bit |
| smask_mode | output | 1 | Stored special-mask bit |

## Verification
The bench walks through every shape of initialization sequence: two words, three words with a cascade word, three words with a mode word, and all four words. A design that counted words wrongly would either raise `init_done` early, or take a mask write as a cascade word or mode word. One sequence is restarted after its base word, which catches a design that keeps the stale word count. Random mask, command, read-select and read traffic, including read-select writes with bit 1 clear and writes with bit 7 set, exposes a select bit that moves when it should not, or a bus that routes to the wrong register. Writes made before initialization catch a design that lets operational commands through early.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BYTE_W = 8;

  // Write-byte bit positions that decide routing and fields
  localparam int unsigned B_W4EN  = 0;
  localparam int unsigned B_SNGL  = 1;
  localparam int unsigned B_LEVEL = 3;
  localparam int unsigned B_START = 4;
  localparam int unsigned B_AEOI  = 1;
  localparam int unsigned B_SFN   = 4;
  localparam int unsigned B_RSRC  = 0;
  localparam int unsigned B_RSEN  = 1;
  localparam int unsigned B_POLL  = 2;
  localparam int unsigned B_OP3   = 3;
  localparam int unsigned B_SMSET = 5;
  localparam int unsigned B_SMEN  = 6;
  localparam int unsigned B_RSVD  = 7;

  typedef enum logic [2:0] {
    SQ_OFF, SQ_BASE, SQ_CASC, SQ_MODE, SQ_RUN
  } seq_state_t;

  typedef enum logic [2:0] {
    WK_NONE, WK_START, WK_DATA, WK_CMD, WK_RSEL
  } wr_kind_t;
endpackage

// File: rtl/irqc_wr_decode.sv
module irqc_wr_decode
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              wr_en,
  input  logic              port_sel,
  input  logic [DATA_W-1:0] wr_data,
  output wr_kind_t          kind
);
  always_comb begin
    kind = WK_NONE;
    if (wr_en) begin
      if (port_sel)                   kind = WK_DATA;
      else if (wr_data[B_START])      kind = WK_START;
      else if (!wr_data[B_OP3])       kind = WK_CMD;
      else if (!wr_data[B_RSVD])      kind = WK_RSEL;
      else                            kind = WK_NONE;
    end
  end
endmodule

// File: rtl/irqc_init_fsm.sv
module irqc_init_fsm
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_kind_t          kind,
  input  logic [DATA_W-1:0] wr_data,
  output logic              init_done,
  output logic              level_trig,
  output logic              single_mode,
  output logic              need_w4,
  output logic [DATA_W-1:0] base_type,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic              auto_eoi,
  output logic              nested_special
);
  seq_state_t state_q, after_base, after_casc;

  always_comb begin
    after_casc = need_w4 ? SQ_MODE : SQ_RUN;
    after_base = single_mode ? after_casc : SQ_CASC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= SQ_OFF;
      init_done      <= 1'b0;
      level_trig     <= 1'b0;
      single_mode    <= 1'b0;
      need_w4        <= 1'b0;
      base_type      <= '0;
      cascade_cfg    <= '0;
      auto_eoi       <= 1'b0;
      nested_special <= 1'b0;
    end else if (kind == WK_START) begin
      state_q        <= SQ_BASE;
      init_done      <= 1'b0;
      level_trig     <= wr_data[B_LEVEL];
      single_mode    <= wr_data[B_SNGL];
      need_w4        <= wr_data[B_W4EN];
      cascade_cfg    <= '0;
      auto_eoi       <= 1'b0;
      nested_special <= 1'b0;
    end else if (kind == WK_DATA) begin
      unique case (state_q)
        SQ_BASE: begin
          base_type <= wr_data;
          state_q   <= after_base;
          init_done <= (after_base == SQ_RUN);
        end
        SQ_CASC: begin
          cascade_cfg <= wr_data;
          state_q     <= after_casc;
          init_done   <= (after_casc == SQ_RUN);
        end
        SQ_MODE: begin
          auto_eoi       <= wr_data[B_AEOI];
          nested_special <= wr_data[B_SFN];
          state_q        <= SQ_RUN;
          init_done      <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_op_regs.sv
module irqc_op_regs
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_kind_t          kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              init_done,
  output logic [DATA_W-1:0] irq_mask,
  output logic              cmd_strobe,
  output logic [DATA_W-1:0] cmd_code,
  output logic              rd_sel_isr,
  output logic              poll_req,
  output logic              smask_mode
);
  logic live;
  assign live = init_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask   <= '0;
      cmd_strobe <= 1'b0;
      cmd_code   <= '0;
      rd_sel_isr <= 1'b0;
      poll_req   <= 1'b0;
      smask_mode <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      unique case (kind)
        WK_START: begin
          irq_mask   <= '0;
          rd_sel_isr <= 1'b0;
          poll_req   <= 1'b0;
          smask_mode <= 1'b0;
        end
        WK_DATA: if (live) irq_mask <= wr_data;
        WK_CMD: if (live) begin
          cmd_strobe <= 1'b1;
          cmd_code   <= wr_data;
        end
        WK_RSEL: if (live) begin
          if (wr_data[B_RSEN]) rd_sel_isr <= wr_data[B_RSRC];
          poll_req <= wr_data[B_POLL];
          if (wr_data[B_SMEN]) smask_mode <= wr_data[B_SMSET];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic              rd_sel_isr,
  input  logic [DATA_W-1:0] irq_mask,
  input  logic [DATA_W-1:0] isr_in,
  input  logic [DATA_W-1:0] irr_in,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] even_src, next_rd;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign even_src[b] = rd_sel_isr ? isr_in[b] : irr_in[b];
    assign next_rd[b]  = port_sel ? irq_mask[b] : even_src[b];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= next_rd;
  end
endmodule

// File: rtl/irqc_cmdword_seq.sv
module irqc_cmdword_seq
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] isr_in,
  input  logic [DATA_W-1:0] irr_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              init_done,
  output logic              level_trig,
  output logic              single_mode,
  output logic              need_w4,
  output logic [DATA_W-1:0] base_type,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic              auto_eoi,
  output logic              nested_special,
  output logic [DATA_W-1:0] irq_mask,
  output logic              cmd_strobe,
  output logic [DATA_W-1:0] cmd_code,
  output logic              rd_sel_isr,
  output logic              poll_req,
  output logic              smask_mode
);
  wr_kind_t kind;

  irqc_wr_decode #(.DATA_W(DATA_W)) dec_i (
    .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data), .kind(kind)
  );

  irqc_init_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .kind(kind), .wr_data(wr_data),
    .init_done(init_done), .level_trig(level_trig),
    .single_mode(single_mode), .need_w4(need_w4),
    .base_type(base_type), .cascade_cfg(cascade_cfg),
    .auto_eoi(auto_eoi), .nested_special(nested_special)
  );

  irqc_op_regs #(.DATA_W(DATA_W)) ops_i (
    .clk(clk), .rst(rst), .kind(kind), .wr_data(wr_data),
    .init_done(init_done), .irq_mask(irq_mask),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
    .rd_sel_isr(rd_sel_isr), .poll_req(poll_req), .smask_mode(smask_mode)
  );

  irqc_read_port #(.DATA_W(DATA_W)) rdp_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .port_sel(port_sel),
    .rd_sel_isr(rd_sel_isr), .irq_mask(irq_mask),
    .isr_in(isr_in), .irr_in(irr_in), .rd_data(rd_data)
  );
endmodule

// File: rtl/irqc_cmdword_seq_chk.sv
module irqc_cmdword_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              port_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              init_done,
  input logic [DATA_W-1:0] irq_mask,
  input logic              cmd_strobe,
  input logic              rd_sel_isr
);
  // R2: a start word always drops initialization and clears the mask
  p_start_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_sel && wr_data[4]) |=> (!init_done && irq_mask == '0));

  // R6: initialization only completes on an odd-port word
  p_done_after_word_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(wr_en && port_sel));

  // R7: nothing reaches the mask before initialization completes
  p_mask_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(init_done) |-> $stable(irq_mask));

  // R9: a strobe follows only a live priority/EOI command
  p_strobe_source_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> $past(wr_en && !port_sel && !wr_data[4] && !wr_data[3] && init_done));

  // R8: odd-port reads return the mask seen at the read
  p_mask_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel) |=> rd_data == $past(irq_mask));

  // R10: read select moves only on even-port writes
  p_rsel_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !port_sel) |=> $stable(rd_sel_isr));

  // R11: read data holds when no read is made
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind irqc_cmdword_seq irqc_cmdword_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
  .wr_data(wr_data), .rd_data(rd_data), .init_done(init_done),
  .irq_mask(irq_mask), .cmd_strobe(cmd_strobe), .rd_sel_isr(rd_sel_isr)
);

// File: tb/irqc_cmdword_seq_tb_top.sv
module irqc_cmdword_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wr_data = '0, isr_in = '0, irr_in = '0;
  logic [7:0] rd_data, base_type, cascade_cfg, irq_mask, cmd_code;
  logic init_done, level_trig, single_mode, need_w4, auto_eoi, nested_special;
  logic cmd_strobe, rd_sel_isr, poll_req, smask_mode;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_mask;
  logic m_rsel;

  always #5 clk = ~clk;

  irqc_cmdword_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .port_sel(port_sel),
    .wr_data(wr_data), .isr_in(isr_in), .irr_in(irr_in), .rd_data(rd_data),
    .init_done(init_done), .level_trig(level_trig), .single_mode(single_mode),
    .need_w4(need_w4), .base_type(base_type), .cascade_cfg(cascade_cfg),
    .auto_eoi(auto_eoi), .nested_special(nested_special), .irq_mask(irq_mask),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .rd_sel_isr(rd_sel_isr),
    .poll_req(poll_req), .smask_mode(smask_mode)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; port_sel = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic p, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; port_sel = p;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  function automatic logic [7:0] exp_rd(input logic p, input logic rs,
                                        input logic [7:0] m, input logic [7:0] is,
                                        input logic [7:0] ir);
    return p ? m : (rs ? is : ir);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!init_done && irq_mask == 0 && !cmd_strobe && !rd_sel_isr && rd_data == 0,
        "R1 during reset", {init_done, rd_sel_isr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!init_done && irq_mask == 0 && !poll_req && !smask_mode, "R1 after reset", init_done, 0);

    // R7: writes ignored before init
    wr(1'b1, 8'hA5);
    chk(irq_mask == 0, "R7 odd write pre-init", irq_mask, 0);
    wr(1'b0, 8'h20);
    chk(!cmd_strobe, "R7 command pre-init", cmd_strobe, 0);

    // Two-word sequence: single mode, no mode word
    wr(1'b0, 8'h1A);
    chk(!init_done && level_trig && single_mode && !need_w4, "R2 start fields",
        {level_trig, single_mode, need_w4}, 3'b110);
    wr(1'b1, 8'h40);
    chk(base_type == 8'h40, "R3 base", base_type, 8'h40);
    chk(init_done, "R6 two-word done", init_done, 1);
    wr(1'b1, 8'h3C);
    chk(cascade_cfg == 0 && irq_mask == 8'h3C, "R4 no cascade word in single mode",
        cascade_cfg, 0);
    rd(1'b1, v);
    chk(v == 8'h3C, "R8 mask read", v, 8'h3C);

    // Three words with cascade
    wr(1'b0, 8'h10);
    chk(irq_mask == 0 && !init_done, "R2 restart clears mask", irq_mask, 0);
    wr(1'b1, 8'h08);
    chk(!init_done, "R6 not done after base", init_done, 0);
    wr(1'b1, 8'h80);
    chk(cascade_cfg == 8'h80 && init_done, "R4 cascade word", cascade_cfg, 8'h80);

    // Three words with mode word
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h50);
    chk(!init_done, "R6 not done before mode word", init_done, 0);
    wr(1'b1, 8'h12);
    chk(auto_eoi && nested_special && init_done, "R5 mode word", {auto_eoi, nested_special}, 2'b11);

    // Restart partway through a four-word sequence
    wr(1'b0, 8'h19);
    wr(1'b1, 8'h60);
    chk(!init_done, "R6 four-word partial", init_done, 0);
    wr(1'b0, 8'h12);
    chk(!auto_eoi && !nested_special && !need_w4, "R2 restart mid sequence", auto_eoi, 0);
    wr(1'b1, 8'h70);
    chk(base_type == 8'h70 && init_done, "R3 base after restart", base_type, 8'h70);

    // Full four-word sequence
    wr(1'b0, 8'h19);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    chk(!init_done && cascade_cfg == 8'h04, "R4 cascade in four-word", cascade_cfg, 8'h04);
    wr(1'b1, 8'h02);
    chk(init_done && auto_eoi && !nested_special, "R5 four-word mode", {auto_eoi, nested_special}, 2'b10);
    chk(irq_mask == 0, "R7 init words do not touch mask", irq_mask, 0);

    // R9 command strobe
    @(negedge clk);
    wr_en = 1'b1; port_sel = 1'b0; wr_data = 8'h67;
    @(negedge clk);
    wr_en = 1'b0;
    chk(cmd_strobe && cmd_code == 8'h67, "R9 command strobe", cmd_code, 8'h67);
    @(negedge clk);
    chk(!cmd_strobe, "R9 strobe one cycle", cmd_strobe, 0);

    // R10 stored mode bits
    wr(1'b0, 8'h6C);
    chk(poll_req && smask_mode, "R10 poll and special mask", {poll_req, smask_mode}, 2'b11);
    wr(1'b0, 8'h28);
    chk(!poll_req && smask_mode, "R10 special mask held without enable", smask_mode, 1);

    m_mask = 8'h00; m_rsel = 1'b0;
    isr_in = 8'h5A; irr_in = 8'hC3;
    rd(1'b0, v);
    chk(v == 8'hC3, "R11 default request read", v, 8'hC3);

    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      logic [7:0] d;
      op = $urandom % 6;
      d = 8'($urandom);
      case (op)
        0: begin
          wr(1'b1, d); m_mask = d;
          chk(irq_mask == m_mask, "R8 random mask", irq_mask, m_mask);
        end
        1: begin
          d = (d & 8'h67) | 8'h08;
          wr(1'b0, d);
          if (d[1]) m_rsel = d[0];
          chk(rd_sel_isr == m_rsel && poll_req == d[2], "R10 random select", rd_sel_isr, m_rsel);
        end
        2: begin
          wr(1'b0, (d & 8'hEF) | 8'h88);
          chk(rd_sel_isr == m_rsel && !cmd_strobe, "R10 bit7 write ignored", rd_sel_isr, m_rsel);
        end
        3: begin
          d = d & 8'hE7;
          wr(1'b0, d);
          chk(cmd_strobe && cmd_code == d && irq_mask == m_mask, "R9 random command", cmd_code, d);
        end
        default: begin
          logic p;
          p = op[0];
          isr_in = 8'($urandom); irr_in = 8'($urandom);
          rd(p, v);
          chk(v == exp_rd(p, m_rsel, m_mask, isr_in, irr_in), "R11 random read", v,
              exp_rd(p, m_rsel, m_mask, isr_in, irr_in));
          @(negedge clk);
          chk(v == rd_data, "R11 read data holds", rd_data, v);
        end
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule